// File: doc/BRIEF.md
# Integer Compare and Byte-Match Unit

This unit is a helper stage for a 32-bit integer datapath. It accepts two operands, `opa` and `opb`, a 3-bit operation code and a carry-in. It computes one of four 32-bit results: a signed compare, an unsigned compare, a leading-zero count, or a search for the first matching byte. Alongside the selected result it always computes the carry-out of `opa + opb + cin`.

All results are formed combinationally and captured in one output register stage. The stage loads only on a cycle where `in_valid` is high. `out_valid` reports one clock later that fresh values are present.

Both compare operations return the difference `opb - opa`. When the two operands have different top bits, the sign bit of that difference is replaced by the sign bit of one operand. As a result, bit 31 of the result is 1 exactly when `opa` is greater than `opb` under the chosen interpretation.

Top module: `cmpbyte_unit`

## Requirements
- R1: With op code 0 (signed compare), the result is `opb + ~opa + 1`. When bit 31 of `opa` and bit 31 of `opb` differ, bit 31 of that value is replaced by bit 31 of `opb` and bits 30:0 are kept. Bit 31 of the result then equals (signed `opa` > signed `opb`).
- R2: With op code 1 (unsigned compare), the result is `opb + ~opa + 1`. When the top bits differ, bit 31 is replaced by bit 31 of `opa`. Bit 31 of the result then equals (unsigned `opa` > unsigned `opb`).
- R3: With op code 2, the result is the number of zero bits in `opa` above its highest set bit. The result is 32 when `opa` is zero.
- R4: With op code 3, the bytes of `opa` and `opb` are compared lane by lane. The result is 1 when bits 31:24 match, 2 for bits 23:16, 3 for bits 15:8 and 4 for bits 7:0. Only the highest matching lane is reported, and the result is 0 when no lane matches.
- R5: `carry_out` is bit 32 of the 33-bit sum `opa + opb + cin`, for every op code. It is therefore 1 whenever `opb` is all ones and `cin` is 1.
- R6: Op codes 4 to 7 are illegal. For these codes the result is 0 and `illegal_op` is 1. For op codes 0 to 3, `illegal_op` is 0.
- R7: `out_valid` equals the value `in_valid` had one clock earlier. `result`, `carry_out` and `illegal_op` load only on a clock edge where `in_valid` is high. Otherwise they hold their values.
- R8: While `rst_n` is low, `out_valid`, `result`, `carry_out` and `illegal_op` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and op code are valid this cycle |
| op | input | 3 | Operation code (0 signed cmp, 1 unsigned cmp, 2 leading zeros, 3 byte match) |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| cin | input | 1 | Carry-in for the carry-out computation |
| out_valid | output | 1 | Registered results are fresh |
| result | output | 32 | Registered result of the selected operation |
| carry_out | output | 1 | Registered carry of opa + opb + cin |
| illegal_op | output | 1 | Registered flag for an unused op code |

## Verification
The bench targets operand pairs whose top bits differ. A compare that forgets the sign override, or takes the override from the wrong operand, gives the wrong sign there and so inverts the ordering.

For the byte search, it builds operands in which several lanes match at once. A search with the wrong priority or lane numbering then reports a lower lane or a shifted index.

It also applies an all-zero and an all-ones operand to the leading-zero count, and the carry cases where `opb` is all ones with `cin` set. Between transactions it drops `in_valid` with new operands on the inputs, so that a register that loads without `in_valid` is caught.

// File: rtl/cmpbyte_pkg.sv
package cmpbyte_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_SCMP  = 3'd0,
    OP_UCMP  = 3'd1,
    OP_LZC   = 3'd2,
    OP_BSCAN = 3'd3
  } op_e;
endpackage

// File: rtl/cmp_core.sv
module cmp_core #(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] scmp,
  output logic [W-1:0] ucmp
);
  function automatic logic [W-1:0] diff_fix(input logic [W-1:0] a, input logic [W-1:0] b,
                                            input logic use_b);
    logic [W-1:0] d;
    d = b + ~a + 1'b1;
    if (a[W-1] != b[W-1]) d[W-1] = use_b ? b[W-1] : a[W-1];
    return d;
  endfunction

  always_comb begin
    scmp = diff_fix(opa, opb, 1'b1);
    ucmp = diff_fix(opa, opb, 1'b0);
  end
endmodule

// File: rtl/lzc_core.sv
module lzc_core #(
  parameter int W  = 32,
  parameter int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  val,
  output logic [CW-1:0] cnt
);
  function automatic logic [CW-1:0] lead_zeros(input logic [W-1:0] v);
    logic [CW-1:0] c;
    c = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (v[i]) c = CW'(W - 1 - i);
    end
    return c;
  endfunction

  always_comb cnt = lead_zeros(val);

  always_comb begin
    if (val != '0) begin
      p_lzc_top_bit_r3: assert (val[W - 1 - int'(cnt)])
        else $error("lzc count does not point at highest set bit");
    end else begin
      p_lzc_zero_r3: assert (cnt == CW'(W))
        else $error("lzc of zero is not W");
    end
  end
endmodule

// File: rtl/bytescan_core.sv
module bytescan_core #(
  parameter int W  = 32,
  parameter int LW = 8,
  parameter int NL = W / LW,
  parameter int IW = $clog2(NL + 1)
) (
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  output logic [IW-1:0] idx
);
  logic [NL-1:0] lane_eq;
  logic [NL-1:0] lane_first;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    localparam int HI = W - 1 - g * LW;
    assign lane_eq[g] = (opa[HI -: LW] == opb[HI -: LW]);
    if (g == 0) begin : g_top
      assign lane_first[g] = lane_eq[g];
    end else begin : g_low
      assign lane_first[g] = lane_eq[g] & ~|lane_eq[g-1:0];
    end
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NL; i++) begin
      if (lane_first[i]) idx = IW'(i + 1);
    end
  end

  always_comb begin
    p_one_winner_r4: assert ($onehot0(lane_first))
      else $error("more than one lane reported as first match");
    p_miss_zero_r4: assert ((lane_eq != '0) || (idx == '0))
      else $error("index nonzero without any matching lane");
  end
endmodule

// File: rtl/cmpbyte_unit.sv
module cmpbyte_unit
  import cmpbyte_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int LANE  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  op,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             cin,
  output logic             out_valid,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             illegal_op
);
  localparam int NLANES = WIDTH / LANE;
  localparam int CNT_W  = $clog2(WIDTH) + 1;
  localparam int IDX_W  = $clog2(NLANES + 1);

  logic [WIDTH-1:0] scmp_w, ucmp_w;
  logic [CNT_W-1:0] lzc_w;
  logic [IDX_W-1:0] bidx_w;
  logic [WIDTH-1:0] res_d;
  logic             ill_d;
  logic             carry_d;

  cmp_core #(.W(WIDTH)) u_cmp (.opa(opa), .opb(opb), .scmp(scmp_w), .ucmp(ucmp_w));

  lzc_core #(.W(WIDTH), .CW(CNT_W)) u_lzc (.val(opa), .cnt(lzc_w));

  bytescan_core #(.W(WIDTH), .LW(LANE), .NL(NLANES), .IW(IDX_W)) u_scan (
    .opa(opa), .opb(opb), .idx(bidx_w)
  );

  function automatic logic add_carry(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                                     input logic c);
    logic [WIDTH:0] s;
    s = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, c};
    return s[WIDTH];
  endfunction

  always_comb begin
    carry_d = add_carry(opa, opb, cin);
    ill_d   = 1'b0;
    unique case (op)
      OP_SCMP:  res_d = scmp_w;
      OP_UCMP:  res_d = ucmp_w;
      OP_LZC:   res_d = WIDTH'(lzc_w);
      OP_BSCAN: res_d = WIDTH'(bidx_w);
      default: begin
        res_d = '0;
        ill_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      result     <= '0;
      carry_out  <= 1'b0;
      illegal_op <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result     <= res_d;
        carry_out  <= carry_d;
        illegal_op <= ill_d;
      end
    end
  end

  p_valid_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(carry_out) && $stable(illegal_op)));
  p_scmp_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_SCMP) |=>
      (result[WIDTH-1] == ($signed($past(opa)) > $signed($past(opb)))));
  p_ucmp_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_UCMP) |=> (result[WIDTH-1] == ($past(opa) > $past(opb))));
  p_illegal_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op[OP_W-1]) |=> (illegal_op && result == '0));
  p_carry_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cin && opb == '1) |=> carry_out);
endmodule

// File: tb/tb_cmpbyte_unit.sv
module tb_cmpbyte_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] opa = '0, opb = '0;
  logic        cin = 1'b0;
  logic        out_valid, carry_out, illegal_op;
  logic [31:0] result;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmpbyte_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .opa(opa), .opb(opb),
    .cin(cin), .out_valid(out_valid), .result(result), .carry_out(carry_out),
    .illegal_op(illegal_op)
  );

  function automatic logic [31:0] m_cmp(input logic [31:0] a, input logic [31:0] b,
                                        input logic is_signed);
    logic [31:0] d;
    logic gt;
    d = b - a;
    gt = is_signed ? ($signed(a) > $signed(b)) : (a > b);
    return {gt, d[30:0]};
  endfunction

  function automatic logic [31:0] m_lzc(input logic [31:0] a);
    int n = 0;
    for (int i = 31; i >= 0; i--) begin
      if (a[i]) break;
      n++;
    end
    return 32'(n);
  endfunction

  function automatic logic [31:0] m_scan(input logic [31:0] a, input logic [31:0] b);
    for (int k = 1; k <= 4; k++) begin
      if (a[39-8*k -: 8] == b[39-8*k -: 8]) return 32'(k);
    end
    return 32'd0;
  endfunction

  function automatic logic m_carry(input logic [31:0] a, input logic [31:0] b, input logic c);
    longint unsigned s;
    s = longint'(a) + longint'(b) + longint'(c);
    return s > 64'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] m_res(input logic [2:0] o, input logic [31:0] a,
                                        input logic [31:0] b);
    case (o)
      3'd0: return m_cmp(a, b, 1'b1);
      3'd1: return m_cmp(a, b, 1'b0);
      3'd2: return m_lzc(a);
      3'd3: return m_scan(a, b);
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic apply(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic c);
    logic [31:0] er;
    logic ec, ei;
    @(negedge clk);
    in_valid = 1'b1; op = o; opa = a; opb = b; cin = c;
    er = m_res(o, a, b);
    ec = m_carry(a, b, c);
    ei = (o >= 3'd4);
    @(posedge clk); #1;
    chk(req_of(o), result, er);
    chk("R5 carry", 32'(carry_out), 32'(ec));
    chk("R6 illegal flag", 32'(illegal_op), 32'(ei));
    chk("R7 valid high", 32'(out_valid), 32'd1);
    @(negedge clk);
    in_valid = 1'b0; op = ~o; opa = ~a; opb = b ^ 32'h0F0F_0F0F; cin = ~c;
    @(posedge clk); #1;
    chk("R7 hold result", result, er);
    chk("R7 hold carry", 32'(carry_out), 32'(ec));
    chk("R7 valid low", 32'(out_valid), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk("R8 out_valid", 32'(out_valid), 32'd0);
    chk("R8 result", result, 32'd0);
    chk("R8 carry", 32'(carry_out), 32'd0);
    chk("R8 illegal", 32'(illegal_op), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1/R2: sign-override corners
    apply(3'd0, 32'h8000_0000, 32'h7FFF_FFFF, 1'b0);
    apply(3'd0, 32'h7FFF_FFFF, 32'h8000_0000, 1'b0);
    apply(3'd1, 32'h8000_0000, 32'h7FFF_FFFF, 1'b0);
    apply(3'd1, 32'h0000_0001, 32'hFFFF_FFFF, 1'b0);
    apply(3'd0, 32'h1234_5678, 32'h1234_5678, 1'b0);
    apply(3'd1, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 1'b0);
    // R3 corners
    apply(3'd2, 32'h0000_0000, 32'h0, 1'b0);
    apply(3'd2, 32'hFFFF_FFFF, 32'h0, 1'b0);
    apply(3'd2, 32'h0000_0001, 32'h0, 1'b0);
    apply(3'd2, 32'h0001_0000, 32'h0, 1'b0);
    // R4 priority and miss
    apply(3'd3, 32'hAABB_CCDD, 32'hAABB_CCDD, 1'b0);
    apply(3'd3, 32'hAABB_CCDD, 32'h00BB_00DD, 1'b0);
    apply(3'd3, 32'hAABB_CCDD, 32'h0000_00DD, 1'b0);
    apply(3'd3, 32'hAABB_CCDD, 32'h1122_3344, 1'b0);
    // R5 carry corners
    apply(3'd0, 32'h0000_0000, 32'hFFFF_FFFF, 1'b1);
    apply(3'd1, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0);
    apply(3'd2, 32'h8000_0000, 32'h8000_0000, 1'b0);
    // R6 illegal codes
    for (int k = 4; k < 8; k++) apply(3'(k), 32'hDEAD_BEEF, 32'h1357_9BDF, 1'b1);

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a, b;
      logic [2:0] o;
      a = $urandom;
      b = $urandom;
      o = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 1) == 1) begin
        for (int l = 0; l < 4; l++)
          if ($urandom_range(0, 1) == 1) b[8*l +: 8] = a[8*l +: 8];
      end
      if ($urandom_range(0, 7) == 0) a = a >> $urandom_range(0, 31);
      apply(o, a, b, 1'($urandom_range(0, 1)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule